// File: doc/BRIEF.md
# Bus-Attached Byte Serial Transmitter

This block is a transmit-only asynchronous serial port that sits on a simple processor bus with an 8-bit data path and a 16-bit address. Software starts a character by storing a byte to a fixed transmit address at the top of the address space. The block then shifts the byte out on a single line as one low start bit, eight data bits with the least significant bit first, and one high stop bit. When no character is being sent, the line rests high.

A second fixed address holds a status byte. Its lowest bit reads 1 while a character is on the line. Software polls this address and writes the next byte only once the bit has cleared. The bus uses single-cycle strobes. A store presents address and data with the write strobe high for one clock. A load raises the read strobe for one clock, and the addressed byte appears on the read-data bus for exactly one cycle, in the cycle after the strobe.

Each serial bit is held for a number of clock cycles given by a parameter, so the bit rate is the clock frequency divided by that parameter.

Top module: `sertx_top`

## Requirements
- R1: After reset the serial line is high, the read-data bus is 0, and a status read returns 0.
- R2: A write strobe to address 0xFFFF while the port is idle latches the data byte. The line goes low in the cycle after the strobe and stays low for CLKS_PER_BIT cycles.
- R3: After the start bit come eight data bits, bit 0 first. Each bit is held unchanged for CLKS_PER_BIT cycles.
- R4: After the eighth data bit the line is driven high for CLKS_PER_BIT cycles and the port returns to idle. A whole character lasts exactly 10 × CLKS_PER_BIT cycles.
- R5: A read strobe to address 0xFFFE puts the status byte on the read-data bus in the next cycle, for one cycle only. Bit 0 is 1 when a character was in progress in the strobe cycle, and bits 7..1 are 0.
- R6: A write to 0xFFFF while a character is in progress is ignored. The character being sent is unchanged and no extra character follows.
- R7: Writes to any address other than 0xFFFF, including 0xFFFE, start no character.
- R8: A read of any address other than 0xFFFE returns 0 on the read-data bus.
- R9: A write issued as soon as a status read has returned 0 is accepted and starts a new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Bus address |
| busWrData | input | 8 | Bus write data |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe |
| busRdData | output | 8 | Read data, valid in the cycle after a read strobe |
| txLine | output | 1 | Serial output, high when idle |

## Verification
The start bit is due in the first cycle after the clock edge that samples the write strobe. Bit k of the character then occupies the k-th window of CLKS_PER_BIT cycles, counted from that edge. The monitor aligns to the first low cycle and then samples the first, middle and last cycle of every bit window, so a window that is one cycle too long or too short is caught.

Status data is due exactly one cycle after the read strobe. The bench reads the bus in that cycle and then checks that the bus is back to 0 in the following cycle. The window of ignored writes is checked at the line: after a rejected write, the bench expects no extra start bit and a status read of 0.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } txState_e;

  typedef enum logic [1:0] {
    LINE_MARK  = 2'd0,
    LINE_SPACE = 2'd1,
    LINE_BIT   = 2'd2
  } lineSel_e;

  typedef struct packed {
    logic     loadByte;
    logic     shiftOut;
    logic     timerRun;
    logic     busy;
    lineSel_e lineSel;
  } ctrlStrb_t;

endpackage

// File: rtl/sertx_decode.sv
module sertx_decode #(
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] TX_ADDR   = '1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '1 - 1'b1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output logic              txWrHit,
  output logic              statRdHit
);

  always_comb begin
    txWrHit   = busWr && (busAddr == TX_ADDR);
    statRdHit = busRd && (busAddr == STAT_ADDR);
  end

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txWrHit,
  input  logic      bitTick,
  output ctrlStrb_t strb
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  txState_e        curState, nxtState;
  logic [BIT_W-1:0] bitIdx;

  always_comb begin
    nxtState      = curState;
    strb.loadByte = 1'b0;
    strb.shiftOut = 1'b0;
    strb.timerRun = 1'b1;
    strb.busy     = 1'b1;
    strb.lineSel  = LINE_MARK;
    unique case (curState)
      ST_IDLE: begin
        strb.timerRun = 1'b0;
        strb.busy     = 1'b0;
        if (txWrHit) begin
          strb.loadByte = 1'b1;
          nxtState      = ST_START;
        end
      end
      ST_START: begin
        strb.lineSel = LINE_SPACE;
        if (bitTick) nxtState = ST_DATA;
      end
      ST_DATA: begin
        strb.lineSel = LINE_BIT;
        if (bitTick) begin
          strb.shiftOut = 1'b1;
          if (bitIdx == LAST_BIT) nxtState = ST_STOP;
        end
      end
      ST_STOP: begin
        strb.lineSel = LINE_MARK;
        if (bitTick) nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_IDLE;
      bitIdx   <= '0;
    end else begin
      curState <= nxtState;
      if (curState != ST_DATA)
        bitIdx <= '0;
      else if (bitTick)
        bitIdx <= bitIdx + 1'b1;
    end
  end

endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              statRdHit,
  input  logic [DATA_W-1:0] busWrData,
  output logic              bitTick,
  output logic [DATA_W-1:0] busRdData,
  output logic              txLine
);

  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] rdReg;

  assign bitTick   = strb.timerRun && (bitCnt == CNT_LAST);
  assign busRdData = rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!strb.timerRun || strb.loadByte || bitTick) begin
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.loadByte) begin
      shiftReg <= busWrData;
    end else if (strb.shiftOut) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (statRdHit) begin
      rdReg <= {{(DATA_W-1){1'b0}}, strb.busy};
    end else begin
      rdReg <= '0;
    end
  end

  always_comb begin
    unique case (strb.lineSel)
      LINE_SPACE: txLine = 1'b0;
      LINE_BIT:   txLine = shiftReg[0];
      default:    txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 16,
  parameter logic [ADDR_W-1:0] TX_ADDR   = 16'hFFFF,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  output logic              txLine
);

  ctrlStrb_t strb;
  logic      txWrHit;
  logic      statRdHit;
  logic      bitTick;
  logic      frameBusy;

  assign frameBusy = strb.busy;

  sertx_decode #(
    .ADDR_W   (ADDR_W),
    .TX_ADDR  (TX_ADDR),
    .STAT_ADDR(STAT_ADDR)
  ) u_decode (
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .txWrHit  (txWrHit),
    .statRdHit(statRdHit)
  );

  sertx_ctrl #(
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .txWrHit(txWrHit),
    .bitTick(bitTick),
    .strb   (strb)
  );

  sertx_dp #(
    .DATA_W      (DATA_W),
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .statRdHit(statRdHit),
    .busWrData(busWrData),
    .bitTick  (bitTick),
    .busRdData(busRdData),
    .txLine   (txLine)
  );

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 16,
  parameter logic [ADDR_W-1:0] TX_ADDR   = 16'hFFFF,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFFFE
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busRdData,
  input logic              txLine,
  input logic              frameBusy
);

  int unsigned runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           runLen <= 0;
    else if (!frameBusy) runLen <= 0;
    else                 runLen <= runLen + 1;
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !frameBusy |-> txLine);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == TX_ADDR && !frameBusy) |=> (frameBusy && !txLine));

  p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameBusy && (runLen % CLKS_PER_BIT) != 0) |-> $stable(txLine));

  p_frame_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameBusy) |-> (runLen == 10 * CLKS_PER_BIT));

  p_status_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == STAT_ADDR) |=>
      (busRdData == {{(DATA_W-1){1'b0}}, $past(frameBusy)}));

  p_other_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busAddr == STAT_ADDR) |=> (busRdData == '0));

endmodule

bind sertx_top sertx_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .TX_ADDR     (TX_ADDR),
  .STAT_ADDR   (STAT_ADDR)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busRd    (busRd),
  .busRdData(busRdData),
  .txLine   (txLine),
  .frameBusy(frameBusy)
);

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;

  localparam int DIV = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic        txLine;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  sertx_top #(.CLKS_PER_BIT(DIV)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .txLine(txLine)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  // Driver: stores a byte and queues the expected character.
  task automatic sendByte(input logic [7:0] d);
    expQ.push_back(d);
    busWrite(16'hFFFF, d);
    check(txLine == 1'b0, "R2 start bit", txLine, 0);
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] v);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    v = busRdData;
    @(negedge clk);
    check(busRdData == 8'h00, "R5 one-cycle read data", busRdData, 0);
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int i = 0; i < 40 * DIV; i++) begin
      busRead(16'hFFFE, v);
      if (v == 8'h00) return;
    end
    check(1'b0, "R4 port never went idle", v, 0);
  endtask

  // Monitor: aligns to each start bit and checks every bit window.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txLine == 1'b0) begin
        logic [7:0] exp;
        if (expQ.size() == 0) begin
          check(1'b0, "R6/R7 unexpected character", 0, 1);
          exp = 8'h00;
        end else begin
          exp = expQ.pop_front();
        end
        for (int k = 0; k < 10; k++) begin
          logic expBit;
          expBit = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : exp[k-1];
          for (int j = 0; j < DIV; j++) begin
            if (k > 0 || j > 0) @(negedge clk);
            if (j == 0 || j == DIV / 2 || j == DIV - 1) begin
              if (k == 0)      check(txLine == expBit, "R2 start window", txLine, expBit);
              else if (k == 9) check(txLine == expBit, "R4 stop window", txLine, expBit);
              else             check(txLine == expBit, "R3 data bit", txLine, expBit);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1 line after reset", txLine, 1);
    check(busRdData == 8'h00, "R1 read bus after reset", busRdData, 0);
    busRead(16'hFFFE, v);
    check(v == 8'h00, "R1 status after reset", v, 0);

    // Main function, status during a character
    sendByte(8'hA5);
    repeat (DIV + 2) @(negedge clk);
    busRead(16'hFFFE, v);
    check(v == 8'h01, "R5 status busy", v, 1);
    busRead(16'hFFFF, v);
    check(v == 8'h00, "R8 read of transmit address", v, 0);
    busRead(16'h1234, v);
    check(v == 8'h00, "R8 read of other address", v, 0);
    waitIdle();

    // R6: write while busy is dropped
    sendByte(8'h3C);
    repeat (5) @(negedge clk);
    busWrite(16'hFFFF, 8'hFF);
    repeat (3 * DIV) @(negedge clk);
    busWrite(16'hFFFF, 8'h00);
    waitIdle();
    repeat (2 * DIV) @(negedge clk);
    check(txLine == 1'b1, "R6 no extra character", txLine, 1);
    busRead(16'hFFFE, v);
    check(v == 8'h00, "R6 status idle after drop", v, 0);

    // R7: writes elsewhere start nothing
    busWrite(16'hFFFE, 8'h55);
    busWrite(16'hFFFD, 8'h00);
    busWrite(16'h7FFF, 8'h00);
    repeat (2 * DIV) @(negedge clk);
    check(txLine == 1'b1, "R7 line stays high", txLine, 1);
    busRead(16'hFFFE, v);
    check(v == 8'h00, "R7 status stays idle", v, 0);

    // R9: back-to-back characters with polling
    sendByte(8'h00);
    waitIdle();
    sendByte(8'hFF);
    waitIdle();
    sendByte(8'h01);
    waitIdle();
    sendByte(8'h80);
    waitIdle();
    repeat (3 * DIV) @(negedge clk);
    check(expQ.size() == 0, "R9 all characters sent", expQ.size(), 0);
    finishRun();
  end

endmodule